// File: doc/BRIEF.md
# Update-Protocol Cache Line Coherence Controller

This block keeps one cache line coherent on a shared snooping bus. The protocol is write-back and update-based: a write to data that other caches also hold sends only the written word on the bus, so the other copies are patched rather than thrown away. A line that is present is always in one of four valid states: exclusive-clean, shared-clean, shared-modified or modified. A line that is not present counts as invalid. The shared-modified state marks the one cache that owns a block whose memory copy is out of date.

On the processor side, the block takes one read or write request at a time and holds it until a one-cycle done pulse. It tells hits apart from misses. On a miss it issues a block read on the bus and samples the wired-OR shared line in the cycle of its grant. Evicting a dirty line writes the whole block back first; evicting a clean line is silent.

On the snoop side, it raises the shared line when a snooped address matches its line. It supplies the block when it is the owner. It applies snooped single-word updates to its copy. Memory is never written by an update transaction. Arbitration and memory timing sit outside the block. A bus transaction completes in the single cycle in which the grant is high. Grant and snoop are never high in the same cycle.

Top module: `upd_line_ctrl`

## Requirements
- R1: After reset the line state output reads invalid (0), there is no bus request, and done is low. State codes are: invalid 0, exclusive-clean 1, shared-clean 2, shared-modified 3, modified 4.
- R2: A read miss issues one block read (bus command 1). In the granted cycle the line loads the fill block and returns the requested word. It ends exclusive-clean if the shared line was low and shared-clean if it was high.
- R3: A write miss issues a block read and merges the written word into the fill. If the shared line was low it ends modified with no update. If it was high it then issues one word update (command 2) carrying the word and ends shared-modified.
- R4: A read hit in any valid state makes no bus request, returns the word with done one cycle after acceptance, and leaves the state unchanged.
- R5: A write hit in exclusive-clean or modified writes locally with no bus transaction and ends modified.
- R6: A write hit in shared-clean or shared-modified issues one word update carrying the written word. The line ends shared-modified if the shared line was high in the granted cycle, and modified if it was low.
- R7: A snooped block read that hits the line raises shared. In modified it flushes the block and moves to shared-modified. In shared-modified it flushes and stays. In exclusive-clean it moves to shared-clean without a flush. In shared-clean it stays without a flush.
- R8: On a shared write hit, the local copy keeps its old value until the grant. A flush during the wait shows the old word.
- R9: A snooped word update that hits the line writes that one word. It moves shared-modified to shared-clean and leaves shared-clean as it is.
- R10: A miss that replaces a modified or shared-modified line first issues a write-back (command 3) carrying the old block, then the block read. Replacing an exclusive-clean or shared-clean line issues only the block read.
- R11: A snoop whose tag does not match raises neither shared nor flush, and leaves the line state and contents unchanged.
- R12: A bus command other than 0 is driven only in a granted cycle, and done is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Processor request, held until done |
| req_write_i | input | 1 | 1 write, 0 read |
| req_tag_i | input | TAG_W | Request block tag |
| req_idx_i | input | IDX_W | Word index in block |
| req_wdata_i | input | WORD_W | Write word |
| req_done_o | output | 1 | Request complete pulse |
| req_rdata_o | output | WORD_W | Read word, valid with done |
| bus_req_o | output | 1 | Bus request |
| bus_gnt_i | input | 1 | Bus grant, one transaction per granted cycle |
| bus_shared_i | input | 1 | Wired-OR shared line, sampled when granted |
| bus_cmd_o | output | 2 | 0 none, 1 block read, 2 word update, 3 write-back |
| bus_tag_o | output | TAG_W | Transaction tag |
| bus_idx_o | output | IDX_W | Update word index |
| bus_word_o | output | WORD_W | Update word |
| bus_blk_o | output | BLK_W | Write-back block |
| bus_fill_i | input | BLK_W | Fill block for a block read |
| snp_valid_i | input | 1 | Snooped transaction valid |
| snp_cmd_i | input | 2 | Snooped command, same codes |
| snp_tag_i | input | TAG_W | Snooped tag |
| snp_idx_i | input | IDX_W | Snooped update word index |
| snp_word_i | input | WORD_W | Snooped update word |
| snp_shared_o | output | 1 | Shared response |
| snp_flush_o | output | 1 | Owner supplies block |
| snp_blk_o | output | BLK_W | Flushed block |
| line_state_o | output | 3 | Coherence state code |

## Verification
The assertions check several rules on every cycle. The line contents stay frozen while a shared write waits for its grant. An update's grant leaves the line in the state the sampled shared line selects. A flush is always followed by shared-modified. Write-backs leave only from dirty states. Done never lasts two cycles. Only the bench's scenarios can show the rest. It sets up each of the four valid states and then applies read hits, write hits with each shared value, matching and non-matching snoops, and a replacement miss. It checks the returned words, the update and write-back payloads, and the state that results.

// File: rtl/upd_coh_pkg.sv
package upd_coh_pkg;
  typedef enum logic [2:0] {
    ST_INV = 3'd0,
    ST_EXC = 3'd1,
    ST_SHC = 3'd2,
    ST_SHM = 3'd3,
    ST_MOD = 3'd4
  } line_st_e;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_READ = 2'd1,
    CMD_UPD  = 2'd2,
    CMD_WB   = 2'd3
  } bus_cmd_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_WB,
    PH_RD,
    PH_UPD
  } phase_e;
endpackage

// File: rtl/upd_line_store.sv
module upd_line_store #(
  parameter int WORD_W = 8,
  parameter int WORDS  = 4,
  parameter int TAG_W  = 4,
  localparam int IDX_W = $clog2(WORDS),
  localparam int BLK_W = WORD_W * WORDS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fill_en_i,
  input  logic [TAG_W-1:0]  fill_tag_i,
  input  logic [BLK_W-1:0]  fill_blk_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [WORD_W-1:0] wr_word_i,
  input  logic              snp_wr_i,
  input  logic [IDX_W-1:0]  snp_idx_i,
  input  logic [WORD_W-1:0] snp_word_i,
  output logic [TAG_W-1:0]  tag_o,
  output logic [BLK_W-1:0]  blk_o
);
  logic [TAG_W-1:0] tag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        tag_q <= '0;
    else if (fill_en_i) tag_q <= fill_tag_i;
  end
  assign tag_o = tag_q;

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic [WORD_W-1:0] w_q;
    logic              sel_wr, sel_snp;
    assign sel_wr  = wr_en_i  && (wr_idx_i  == IDX_W'(g));
    assign sel_snp = snp_wr_i && (snp_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        w_q <= '0;
      else if (fill_en_i) w_q <= sel_wr ? wr_word_i : fill_blk_i[g*WORD_W +: WORD_W];
      else if (sel_wr)    w_q <= wr_word_i;
      else if (sel_snp)   w_q <= snp_word_i;
    end
    assign blk_o[g*WORD_W +: WORD_W] = w_q;
  end

  // own fill and a snooped update belong to different bus cycles
  assert_fill_snoop_excl_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fill_en_i && snp_wr_i));
endmodule

// File: rtl/upd_snoop_fn.sv
module upd_snoop_fn
  import upd_coh_pkg::*;
(
  input  line_st_e st_i,
  input  logic     valid_i,
  input  logic     match_i,
  input  bus_cmd_e cmd_i,
  output line_st_e st_o,
  output logic     shared_o,
  output logic     flush_o,
  output logic     upd_o
);
  always_comb begin
    st_o     = st_i;
    flush_o  = 1'b0;
    upd_o    = 1'b0;
    shared_o = valid_i && match_i && (st_i != ST_INV);
    if (shared_o) begin
      case (cmd_i)
        CMD_READ: begin
          case (st_i)
            ST_MOD:  begin st_o = ST_SHM; flush_o = 1'b1; end
            ST_SHM:  flush_o = 1'b1;
            ST_EXC:  st_o = ST_SHC;
            default: ;
          endcase
        end
        CMD_UPD: begin
          case (st_i)
            ST_SHM:  begin st_o = ST_SHC; upd_o = 1'b1; end
            ST_SHC:  upd_o = 1'b1;
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/upd_line_ctrl.sv
module upd_line_ctrl
  import upd_coh_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int WORDS  = 4,
  parameter int TAG_W  = 4,
  localparam int IDX_W = $clog2(WORDS),
  localparam int BLK_W = WORD_W * WORDS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [TAG_W-1:0]  req_tag_i,
  input  logic [IDX_W-1:0]  req_idx_i,
  input  logic [WORD_W-1:0] req_wdata_i,
  output logic              req_done_o,
  output logic [WORD_W-1:0] req_rdata_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  input  logic              bus_shared_i,
  output logic [1:0]        bus_cmd_o,
  output logic [TAG_W-1:0]  bus_tag_o,
  output logic [IDX_W-1:0]  bus_idx_o,
  output logic [WORD_W-1:0] bus_word_o,
  output logic [BLK_W-1:0]  bus_blk_o,
  input  logic [BLK_W-1:0]  bus_fill_i,
  input  logic              snp_valid_i,
  input  logic [1:0]        snp_cmd_i,
  input  logic [TAG_W-1:0]  snp_tag_i,
  input  logic [IDX_W-1:0]  snp_idx_i,
  input  logic [WORD_W-1:0] snp_word_i,
  output logic              snp_shared_o,
  output logic              snp_flush_o,
  output logic [BLK_W-1:0]  snp_blk_o,
  output logic [2:0]        line_state_o
);
  line_st_e          st_q, st_d, snp_st;
  phase_e            phase_q, phase_d;
  logic              done_q, done_d;
  logic [WORD_W-1:0] rdata_q, rdata_d;
  logic [TAG_W-1:0]  tag_q;
  logic [BLK_W-1:0]  blk;
  logic              fill_en, wr_en, snp_upd, snp_flush, snp_shared;
  logic              hit, accept, dirty;
  bus_cmd_e          cmd;

  upd_line_store #(.WORD_W(WORD_W), .WORDS(WORDS), .TAG_W(TAG_W)) u_store (
    .clk_i, .rst_ni,
    .fill_en_i (fill_en),
    .fill_tag_i(req_tag_i),
    .fill_blk_i(bus_fill_i),
    .wr_en_i   (wr_en),
    .wr_idx_i  (req_idx_i),
    .wr_word_i (req_wdata_i),
    .snp_wr_i  (snp_upd),
    .snp_idx_i (snp_idx_i),
    .snp_word_i(snp_word_i),
    .tag_o     (tag_q),
    .blk_o     (blk)
  );

  upd_snoop_fn u_snoop (
    .st_i    (st_q),
    .valid_i (snp_valid_i),
    .match_i (snp_tag_i == tag_q),
    .cmd_i   (bus_cmd_e'(snp_cmd_i)),
    .st_o    (snp_st),
    .shared_o(snp_shared),
    .flush_o (snp_flush),
    .upd_o   (snp_upd)
  );

  assign hit    = (st_q != ST_INV) && (tag_q == req_tag_i);
  assign dirty  = (st_q == ST_MOD) || (st_q == ST_SHM);
  // a snoop cycle stalls acceptance so the two never race on the state
  assign accept = req_valid_i && !done_q && !snp_valid_i;

  always_comb begin
    st_d    = snp_valid_i ? snp_st : st_q;
    phase_d = phase_q;
    done_d  = 1'b0;
    rdata_d = rdata_q;
    fill_en = 1'b0;
    wr_en   = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (accept) begin
          if (hit) begin
            if (!req_write_i) begin
              rdata_d = blk[req_idx_i*WORD_W +: WORD_W];
              done_d  = 1'b1;
            end else if (st_q == ST_EXC || st_q == ST_MOD) begin
              wr_en  = 1'b1;
              st_d   = ST_MOD;
              done_d = 1'b1;
            end else begin
              phase_d = PH_UPD;
            end
          end else if (dirty) begin
            phase_d = PH_WB;
          end else begin
            st_d    = ST_INV;
            phase_d = PH_RD;
          end
        end
      end
      PH_WB: begin
        if (bus_gnt_i) begin
          st_d    = ST_INV;
          phase_d = PH_RD;
        end
      end
      PH_RD: begin
        if (bus_gnt_i) begin
          fill_en = 1'b1;
          if (!req_write_i) begin
            st_d    = bus_shared_i ? ST_SHC : ST_EXC;
            rdata_d = bus_fill_i[req_idx_i*WORD_W +: WORD_W];
            done_d  = 1'b1;
            phase_d = PH_IDLE;
          end else if (bus_shared_i) begin
            st_d    = ST_SHC;
            phase_d = PH_UPD;
          end else begin
            wr_en   = 1'b1;
            st_d    = ST_MOD;
            done_d  = 1'b1;
            phase_d = PH_IDLE;
          end
        end
      end
      PH_UPD: begin
        if (bus_gnt_i) begin
          wr_en   = 1'b1;
          st_d    = bus_shared_i ? ST_SHM : ST_MOD;
          done_d  = 1'b1;
          phase_d = PH_IDLE;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_INV;
      phase_q <= PH_IDLE;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      st_q    <= st_d;
      phase_q <= phase_d;
      done_q  <= done_d;
      rdata_q <= rdata_d;
    end
  end

  always_comb begin
    cmd = CMD_NONE;
    if (bus_gnt_i) begin
      case (phase_q)
        PH_WB:   cmd = CMD_WB;
        PH_RD:   cmd = CMD_READ;
        PH_UPD:  cmd = CMD_UPD;
        default: cmd = CMD_NONE;
      endcase
    end
  end

  assign bus_req_o    = (phase_q != PH_IDLE);
  assign bus_cmd_o    = cmd;
  assign bus_tag_o    = (phase_q == PH_WB) ? tag_q : req_tag_i;
  assign bus_idx_o    = req_idx_i;
  assign bus_word_o   = req_wdata_i;
  assign bus_blk_o    = (cmd == CMD_WB) ? blk : '0;
  assign snp_shared_o = snp_shared;
  assign snp_flush_o  = snp_flush;
  assign snp_blk_o    = snp_flush ? blk : '0;
  assign req_done_o   = done_q;
  assign req_rdata_o  = rdata_q;
  assign line_state_o = st_q;

  assert_update_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_UPD && !bus_gnt_i && !snp_upd) |=> $stable(blk));

  assert_update_result_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_UPD && bus_gnt_i) |=> (st_q == ($past(bus_shared_i) ? ST_SHM : ST_MOD)));

  assert_flush_owner_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_flush_o |=> (st_q == ST_SHM));

  assert_wb_dirty_only_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cmd_o == CMD_WB) |-> dirty);

  assert_done_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_done_o |=> !req_done_o);

  assert_cmd_in_grant_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cmd_o != CMD_NONE) |-> (bus_gnt_i && bus_req_o));
endmodule

// File: tb/upd_line_ctrl_tb.sv
module upd_line_ctrl_tb;
  localparam int W = 8;
  localparam logic [3:0] TA = 4'h5;
  localparam logic [3:0] TB = 4'hA;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 0, req_write = 0;
  logic [3:0]  req_tag = 0;
  logic [1:0]  req_idx = 0;
  logic [7:0]  req_wdata = 0;
  logic        req_done;
  logic [7:0]  req_rdata;
  logic        bus_req, gnt = 0, shared = 0;
  logic [1:0]  bus_cmd;
  logic [3:0]  bus_tag;
  logic [1:0]  bus_idx;
  logic [7:0]  bus_word;
  logic [31:0] bus_blk, fill = 0;
  logic        snp_valid = 0;
  logic [1:0]  snp_cmd = 0;
  logic [3:0]  snp_tag = 0;
  logic [1:0]  snp_idx = 0;
  logic [7:0]  snp_word = 0;
  logic        snp_shared, snp_flush;
  logic [31:0] snp_blk;
  logic [2:0]  line_state;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;
  logic [31:0] exp_blk;

  always #4 clk = ~clk;

  upd_line_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_tag_i(req_tag),
    .req_idx_i(req_idx), .req_wdata_i(req_wdata), .req_done_o(req_done),
    .req_rdata_o(req_rdata), .bus_req_o(bus_req), .bus_gnt_i(gnt),
    .bus_shared_i(shared), .bus_cmd_o(bus_cmd), .bus_tag_o(bus_tag),
    .bus_idx_o(bus_idx), .bus_word_o(bus_word), .bus_blk_o(bus_blk),
    .bus_fill_i(fill), .snp_valid_i(snp_valid), .snp_cmd_i(snp_cmd),
    .snp_tag_i(snp_tag), .snp_idx_i(snp_idx), .snp_word_i(snp_word),
    .snp_shared_o(snp_shared), .snp_flush_o(snp_flush), .snp_blk_o(snp_blk),
    .line_state_o(line_state)
  );

  function automatic logic [31:0] fill_of(input logic [3:0] t);
    logic [31:0] b;
    for (int i = 0; i < 4; i++) b[i*W +: W] = 8'(t * 16 + i * 3 + 1);
    return b;
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic proc_op(input logic wr, input logic [3:0] tg, input logic [1:0] ix,
                         input logic [7:0] wd, input logic sh,
                         output int n_rd, output int n_upd, output int n_wb,
                         output logic [7:0] rd, output logic [7:0] updw,
                         output logic [31:0] wbb);
    bit got = 0;
    n_rd = 0; n_upd = 0; n_wb = 0; rd = 0; updw = 0; wbb = 0;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_tag = tg; req_idx = ix; req_wdata = wd;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (req_done) begin
        rd = req_rdata; gnt = 0; got = 1;
        break;
      end
      if (gnt) begin
        gnt = 0; shared = 0;
      end else if (bus_req) begin
        gnt = 1; shared = sh; fill = fill_of(tg);
        #1;
        case (bus_cmd)
          2'd1: n_rd++;
          2'd2: begin n_upd++; updw = bus_word; end
          2'd3: begin n_wb++; wbb = bus_blk; end
          default: ;
        endcase
      end
    end
    req_valid = 0;
    if (!got) chk("R12 request completion", 0, 1);
  endtask

  task automatic snoop(input logic [1:0] cmd, input logic [3:0] tg, input logic [1:0] ix,
                       input logic [7:0] wd, output logic sh, output logic fl,
                       output logic [31:0] blk);
    @(negedge clk);
    snp_valid = 1; snp_cmd = cmd; snp_tag = tg; snp_idx = ix; snp_word = wd;
    #1;
    sh = snp_shared; fl = snp_flush; blk = snp_blk;
    @(negedge clk);
    snp_valid = 0;
  endtask

  // Start states: 1 exclusive-clean, 2 shared-clean, 3 shared-modified, 4 modified
  task automatic setup(input int s);
    int a, b, c; logic [7:0] rd, uw; logic [31:0] wb;
    do_reset();
    exp_blk = fill_of(TA);
    case (s)
      1: begin
        proc_op(0, TA, 1, 0, 0, a, b, c, rd, uw, wb);
        chk("R2 read miss data", rd, exp_blk[1*W +: W]);
        chk("R2 read miss one bus read", a, 1);
      end
      2: begin
        proc_op(0, TA, 2, 0, 1, a, b, c, rd, uw, wb);
        chk("R2 read miss shared data", rd, exp_blk[2*W +: W]);
      end
      3: begin
        proc_op(1, TA, 3, 8'h3C, 1, a, b, c, rd, uw, wb);
        exp_blk[3*W +: W] = 8'h3C;
        chk("R3 write miss shared update count", b, 1);
        chk("R3 write miss update word", uw, 8'h3C);
      end
      default: begin
        proc_op(1, TA, 3, 8'hC3, 0, a, b, c, rd, uw, wb);
        exp_blk[3*W +: W] = 8'hC3;
        chk("R3 write miss no update", b, 0);
        chk("R3 write miss bus read", a, 1);
      end
    endcase
    chk(s < 3 ? "R2 state after read miss" : "R3 state after write miss", line_state, s);
  endtask

  task automatic read_word(input logic [1:0] ix, input logic [7:0] exp, input string r);
    int a, b, c; logic [7:0] rd, uw; logic [31:0] wb;
    proc_op(0, TA, ix, 0, 0, a, b, c, rd, uw, wb);
    chk(r, rd, exp);
    chk("R4 read hit no bus", a + b + c, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog R12 actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int a, b, c; logic [7:0] rd, uw; logic [31:0] wb;
    logic sh, fl; logic [31:0] fb;
    int es;

    #1;
    chk("R1 reset state", line_state, 0);
    chk("R1 reset no request", bus_req, 0);
    chk("R1 reset done low", req_done, 0);
    do_reset();
    chk("R1 state after reset", line_state, 0);

    for (int s = 1; s <= 4; s++) begin
      for (int act = 0; act <= 6; act++) begin
        if (act == 4 && (s == 1 || s == 4)) continue;
        setup(s);
        case (act)
          0: begin
            proc_op(0, TA, 2, 0, 1, a, b, c, rd, uw, wb);
            chk("R4 read hit word", rd, exp_blk[2*W +: W]);
            chk("R4 read hit no bus", a + b + c, 0);
            chk("R4 read hit state kept", line_state, s);
          end
          1, 2: begin
            logic shv; logic [7:0] d;
            shv = (act == 2); d = 8'h90 + 8'(s);
            proc_op(1, TA, 1, d, shv, a, b, c, rd, uw, wb);
            if (s == 1 || s == 4) begin
              chk("R5 write hit no bus", a + b + c, 0);
              chk("R5 write hit state", line_state, 4);
            end else begin
              chk("R6 write hit one update", b, 1);
              chk("R6 write hit update word", uw, d);
              chk("R6 write hit state", line_state, shv ? 3 : 4);
            end
            read_word(1, d, "R5 R6 written word readback");
          end
          3: begin
            snoop(2'd1, TA, 0, 0, sh, fl, fb);
            chk("R7 snoop read shared", sh, 1);
            chk("R7 snoop read flush", fl, (s >= 3));
            if (s >= 3) chk("R7 flushed block", fb, exp_blk);
            es = (s == 4) ? 3 : (s == 1) ? 2 : s;
            chk("R7 state after snoop read", line_state, es);
          end
          4: begin
            snoop(2'd2, TA, 0, 8'h5E, sh, fl, fb);
            chk("R9 snoop update shared", sh, 1);
            chk("R9 state after update", line_state, 2);
            read_word(0, 8'h5E, "R9 updated word");
            read_word(2, exp_blk[2*W +: W], "R9 other word kept");
          end
          5: begin
            proc_op(0, TB, 2, 0, 0, a, b, c, rd, uw, wb);
            chk("R10 write-back count", c, (s >= 3));
            if (s >= 3) chk("R10 write-back block", wb, exp_blk);
            chk("R10 block read count", a, 1);
            chk("R10 new line data", rd, 8'(TB * 16 + 2 * 3 + 1));
            chk("R10 new state", line_state, 1);
          end
          default: begin
            snoop(2'd1, TB, 0, 0, sh, fl, fb);
            chk("R11 no shared", sh, 0);
            chk("R11 no flush", fl, 0);
            snoop(2'd2, TB, 2, 8'hEE, sh, fl, fb);
            chk("R11 update miss no shared", sh, 0);
            chk("R11 state kept", line_state, s);
            read_word(2, exp_blk[2*W +: W], "R11 data kept");
          end
        endcase
      end
    end

    // R8: shared write hit waits for grant; flush in the wait shows old data
    setup(3);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_tag = TA; req_idx = 0; req_wdata = 8'h77;
    repeat (3) begin
      @(negedge clk);
      chk("R12 request pending", bus_req, 1);
      chk("R12 no command without grant", bus_cmd, 0);
    end
    snoop(2'd1, TA, 0, 0, sh, fl, fb);
    chk("R8 flush during wait", fl, 1);
    chk("R8 old word in flush", fb[0 +: W], exp_blk[0 +: W]);
    @(negedge clk);
    gnt = 1; shared = 0;
    #1;
    chk("R6 update command in grant", bus_cmd, 2);
    @(negedge clk);
    gnt = 0;
    chk("R12 done pulse", req_done, 1);
    req_valid = 0;
    @(negedge clk);
    chk("R12 done one cycle", req_done, 0);
    chk("R8 state after granted update", line_state, 4);
    read_word(0, 8'h77, "R8 word written after grant");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule